// File: doc/BRIEF.md
# Two-Wire Serial Target Front End

This block is the bus-facing front end of a memory-like target on a two-wire serial bus (I2C style). A fast system clock oversamples the clock line SCL and the data line SDA. From those samples the block finds Start and Stop conditions, shifts in bytes most significant bit first and acknowledges each byte. It also shifts out read bytes and watches whether the controller acknowledges them. SDA is open-drain: the block either pulls the line low or leaves it released.

The first byte after a Start is treated as the address byte. Its least significant bit selects the direction of the data phases that follow. Received bytes leave the block as one-cycle pulses on `rx_valid`. Before each read byte the block raises `tx_req` and expects `tx_data` to be ready by the next falling SCL edge. A `busy` input stands for an internal write cycle still in progress. While it is high the block acknowledges nothing, so a controller can poll until the target answers again. The block does not decode addresses, store data or stretch the clock.

Top module: `i2c_tgt_front`

## Requirements
- R1: A falling SDA while SCL is high is a Start. It is honoured in any state, including in the middle of a transfer (repeated Start). It releases SDA, clears the bit count and makes the next byte an address byte.
- R2: A rising SDA while SCL is high is a Stop. It releases SDA and returns the block to idle. From idle, SCL pulses without a Start produce no `rx_valid`, no `tx_req` and no drive on SDA.
- R3: Bits are sampled on rising SCL, eight per byte, with the first bit landing in `rx_data[7]`. On the eighth rising edge the byte appears on `rx_data` together with a one-cycle `rx_valid` pulse. `rx_first` is 1 for the address byte and 0 for data bytes.
- R4: After each accepted byte, `sda_oe` goes to 1 (SDA pulled low) from the falling edge after the eighth bit until the falling edge of the ninth pulse. `sda_oe` changes only while SCL is low, except for the release caused by a Start or a Stop.
- R5: If `busy` is 1 at the eighth rising SCL edge of a byte, the block gives no acknowledge and raises no `rx_valid`. SDA stays released for the rest of the transfer until a Start or a Stop.
- R6: When the address byte's bit 0 is 1, the data phases are reads and the block transmits. When it is 0, the block receives.
- R7: In a read, `tx_req` pulses for one cycle on the ninth rising SCL edge of the address byte and on the ninth rising edge of every read byte the controller acknowledged. `tx_data` is sampled on the next falling SCL edge and sent MSB first, with `sda_oe`=1 for a 0 bit. SDA is released for the ninth pulse.
- R8: A released (high) SDA on the ninth pulse of a read byte ends the read. No further `tx_req` is raised and SDA stays released until a Start or a Stop.
- R9: Any number of bytes may follow the address byte, and each one is acknowledged and presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | input | 1 | Internal write cycle in progress; suppresses acknowledges |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is accepted |
| rx_first | output | 1 | Accepted byte was the address byte |
| tx_req | output | 1 | One-cycle request for the next read byte |
| tx_data | input | 8 | Read byte, sampled on the falling SCL edge after `tx_req` |

## Verification
A table of write transactions covers several address and data patterns: all zeros, all ones, alternating ends, and one entry with `busy` set. These show that bit order, acknowledge timing and busy suppression depend on the data and not on fixed positions. Directed sequences then cover four cases: a read acknowledged and then refused, a repeated Start that cuts a byte short and switches direction, a long multi-byte write, and `busy` rising mid-transfer. Clocking the bus after a Stop and after a refused read shows that the block stays silent in both cases.

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       busy,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_first,
  output logic       tx_req,
  input  logic [7:0] tx_data
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK, S_WAIT} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       first, rd, ack_ok, more;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_c = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_c = sda_q[1];
  wire sda_p = sda_q[2];
  wire scl_rise  = scl_c & ~scl_p;
  wire scl_fall  = ~scl_c & scl_p;
  wire start_det = scl_c & scl_p & sda_p & ~sda_c;
  wire stop_det  = scl_c & scl_p & ~sda_p & sda_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      first    <= 1'b0;
      rd       <= 1'b0;
      ack_ok   <= 1'b0;
      more     <= 1'b0;
      sda_oe   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
      tx_req   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (start_det) begin
        st     <= S_RX;
        bitcnt <= '0;
        first  <= 1'b1;
        rd     <= 1'b0;
        more   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_c};
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                ack_ok <= ~busy;
                if (!busy) begin
                  rx_valid <= 1'b1;
                  rx_data  <= {sh[6:0], sda_c};
                  rx_first <= first;
                  if (first) rd <= sda_c;
                end
              end
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (ack_ok) begin
                sda_oe <= 1'b1;
                st     <= S_RACK;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_RACK: begin
            if (scl_rise && rd) tx_req <= 1'b1;
            if (scl_fall) begin
              bitcnt <= '0;
              first  <= 1'b0;
              if (rd) begin
                sh     <= tx_data;
                sda_oe <= ~tx_data[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= S_TACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              if (!sda_c) begin
                tx_req <= 1'b1;
                more   <= 1'b1;
              end else begin
                st <= S_WAIT;
              end
            end else if (scl_fall && more) begin
              more   <= 1'b0;
              sh     <= tx_data;
              sda_oe <= ~tx_data[7];
              st     <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end

  AST_START_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && st == S_RX && bitcnt == 4'd0 && first)); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && st == S_IDLE)); // R2
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_c) || $past(start_det) || $past(stop_det))); // R4
  AST_TXREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req); // R7
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_oe); // R8

endmodule

// File: tb/i2c_tgt_front_tb.sv
module i2c_tgt_front_tb;
  localparam int Q = 8;
  localparam int H = 2 * Q;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, rx_valid, rx_first, tx_req;
  logic [7:0] rx_data, tx_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  int rx_cnt = 0, tx_cnt = 0;
  logic [7:0] last_rx = '0;
  logic last_first = 1'b0, oe_seen = 1'b0;

  always #5 clk = ~clk;

  i2c_tgt_front u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first),
    .tx_req(tx_req), .tx_data(tx_data)
  );

  function automatic logic [7:0] txb(int n);
    return 8'h5A ^ 8'(n * 8'h29);
  endfunction
  assign tx_data = txb(tx_cnt);

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_data; last_first <= rx_first; end
    if (tx_req) tx_cnt <= tx_cnt + 1;
    if (sda_oe) oe_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0; w(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
    ack = ~sda_line;
    w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic ack_m);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
      b = {b[6:0], sda_line};
      w(Q); scl = 1'b0; w(Q);
    end
    put_bit(~ack_m);
  endtask

  localparam logic [16:0] WR_TAB [4] = '{
    {8'hA0, 8'h00, 1'b0},
    {8'hA2, 8'hFF, 1'b0},
    {8'h7E, 8'h81, 1'b0},
    {8'h52, 8'h3C, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int rc, tc;
    w(4); rst_n = 1'b1; w(4);
    chk(sda_oe == 1'b0 && rx_valid == 1'b0 && tx_req == 1'b0, "R2 reset", sda_oe, 0);

    // R3 R4 R5 R6: table of write transactions
    foreach (WR_TAB[k]) begin
      busy = WR_TAB[k][0];
      rc = rx_cnt;
      start_c;
      send_byte(WR_TAB[k][16:9], ack);
      if (WR_TAB[k][0]) begin
        chk(ack == 1'b0, "R5 busy nack", ack, 0);
        chk(rx_cnt == rc, "R5 busy no rx", rx_cnt, rc);
      end else begin
        chk(ack == 1'b1, "R4 addr ack", ack, 1);
        chk(last_rx == WR_TAB[k][16:9] && last_first, "R3 addr byte", last_rx, WR_TAB[k][16:9]);
        send_byte(WR_TAB[k][8:1], ack);
        chk(ack == 1'b1, "R4 data ack", ack, 1);
        chk(last_rx == WR_TAB[k][8:1] && !last_first, "R3 data byte", last_rx, WR_TAB[k][8:1]);
        chk(rx_cnt == rc + 2, "R6 write count", rx_cnt, rc + 2);
      end
      stop_c;
      busy = 1'b0;
    end

    // R7 R8: read, ack first byte, refuse second
    tc = tx_cnt;
    start_c;
    send_byte(8'hA1, ack);
    chk(ack == 1'b1 && last_first && last_rx == 8'hA1, "R6 read addr", last_rx, 8'hA1);
    get_byte(b, 1'b1);
    chk(b == txb(tc + 1), "R7 read byte 1", b, txb(tc + 1));
    get_byte(b, 1'b0);
    chk(b == txb(tc + 2), "R7 read byte 2", b, txb(tc + 2));
    chk(tx_cnt == tc + 2, "R7 req count", tx_cnt, tc + 2);
    oe_seen = 1'b0;
    get_byte(b, 1'b0);
    chk(!oe_seen && b == 8'hFF, "R8 released after nack", b, 8'hFF);
    chk(tx_cnt == tc + 2, "R8 no more req", tx_cnt, tc + 2);
    stop_c;

    // R1: repeated Start mid-byte, switch to read
    start_c;
    send_byte(8'hA0, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    rc = rx_cnt; tc = tx_cnt;
    start_c;
    send_byte(8'hA1, ack);
    chk(ack && rx_cnt == rc + 1 && last_first && last_rx == 8'hA1, "R1 repeated start", last_rx, 8'hA1);
    get_byte(b, 1'b0);
    chk(b == txb(tc + 1), "R1 read after restart", b, txb(tc + 1));
    stop_c;

    // R2: clocking after Stop without Start does nothing
    rc = rx_cnt; tc = tx_cnt;
    scl = 1'b0; w(Q);
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) put_bit(i[0]);
    chk(!oe_seen && rx_cnt == rc && tx_cnt == tc, "R2 idle ignores clocks", rx_cnt, rc);
    stop_c;

    // R9: long write
    start_c;
    send_byte(8'hA4, ack);
    for (int i = 0; i < 5; i++) begin
      send_byte(8'(8'h11 * (i + 3)), ack);
      chk(ack && last_rx == 8'(8'h11 * (i + 3)), "R9 multi byte", last_rx, 8'(8'h11 * (i + 3)));
    end
    stop_c;

    // R5: busy rises mid-transfer
    start_c;
    send_byte(8'hA0, ack);
    busy = 1'b1;
    rc = rx_cnt;
    send_byte(8'h66, ack);
    chk(!ack && rx_cnt == rc, "R5 busy mid nack", ack, 0);
    busy = 1'b0;
    oe_seen = 1'b0;
    send_byte(8'h77, ack);
    chk(!ack && !oe_seen && rx_cnt == rc, "R5 stays silent", rx_cnt, rc);
    stop_c;

    w(20);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule